// File: doc/BRIEF.md
# Grouped-Priority DMA Channel Arbiter

This block decides which of up to 32 DMA channels may use a shared memory port. Each channel falls into one of four priority groups. The group is set by bits [3:2] of the channel's index, so the lower and upper sixteen channels interleave through the same four levels. Group 0 holds channels 0-3 and 16-19. Group 1 holds 4-7 and 20-23. Group 2 holds 8-11 and 24-27. Group 3 holds 12-15 and 28-31. Group 0 ranks highest.

Among the members of the best requesting group, the grant rotates. The search starts at the channel just after that group's most recent winner. Once a channel wins, the block holds the grant until that channel pulses the burst-done input. The block then spends one cycle idle and arbitrates again on the next clock.

The port vectors have a fixed width of `PORT_CH`. Only the lowest `NUM_CH` channels are live, and request bits above that count are ignored.

Top module: `dga_arbiter`

## Requirements
- R1: When the arbiter is idle, the winner comes from the lowest-numbered group that has an eligible channel. The group of channel i is (i mod 16) / 4.
- R2: Within the winning group, the winner is the first eligible member in ascending index order after that group's previous winner, wrapping around. After reset, every group starts its search at index 0.
- R3: While a grant is held and burst-done is low, the grant vector, the index and the valid flag stay unchanged, whatever happens on the request and enable inputs.
- R4: Burst-done sampled high while a grant is held makes the valid flag low on the next cycle. A new grant can appear one cycle after that.
- R5: Whenever valid is low, the grant vector is all zeros and the index is 0. This includes the state after reset.
- R6: A channel whose enable bit is low is never granted, even if it requests.
- R7: The grant vector is one-hot while valid is high, and bit `gnt_idx_o` is its set bit.
- R8: Channels at index `NUM_CH` or above are never granted, whatever their request bits hold.
- R9: A lower group may be starved indefinitely. While a higher-group channel keeps requesting, no lower-group channel is ever granted.
- R10: Burst-done while no grant is held has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | PORT_CH | Per-channel request |
| en_i | input | PORT_CH | Per-channel enable; a low bit masks that channel's request |
| burst_done_i | input | 1 | Pulse from the current winner marking the end of its burst |
| gnt_o | output | PORT_CH | One-hot grant vector, all zeros when idle |
| gnt_valid_o | output | 1 | A grant is held |
| gnt_idx_o | output | $clog2(PORT_CH) | Index of the granted channel, 0 when idle |

## Verification
The assertions check on every cycle:
- the grant is one-hot and matches the index;
- an idle output is all zeros;
- a held grant stays unchanged until burst-done;
- a grant is released on the cycle after burst-done;
- a new winner was eligible when it was chosen;
- no channel in a better group was eligible when it was chosen;
- no grant goes to a channel beyond the live count.

Only the bench scenarios can show that the round-robin pointer of each group rotates in the correct order over many grants. They also show that a low group really starves under continuous high-group traffic, and that masked or out-of-range requests produce no grant. The bench compares every cycle against its own arithmetic model of groups and rotation.

// File: rtl/dga_pkg.sv
package dga_pkg;

   localparam int NUM_GROUPS = 4;
   localparam int GRP_W      = 2;

   // priority group of a channel: bits [3:2] of its index
   function automatic logic [GRP_W-1:0] grp_of(input int unsigned ch);
      return GRP_W'((ch >> 2) & 3);
   endfunction

endpackage

// File: rtl/dga_rr_pick.sv
module dga_rr_pick #(
   parameter int N = 32,
   parameter int W = $clog2(N)
) (
   input  logic [N-1:0] cand_i,
   input  logic [W-1:0] last_i,
   output logic         found_o,
   output logic [W-1:0] pick_o
);

   initial begin
      assert (N >= 2 && (1 << W) == N)
         else $error("dga_rr_pick: N must be a power of two");
   end

   // scan starts one past the last winner and wraps
   always_comb begin
      logic [W-1:0] probe;
      found_o = 1'b0;
      pick_o  = '0;
      for (int k = 1; k <= N; k++) begin
         probe = W'((int'(last_i) + k) % N);
         if (!found_o && cand_i[probe]) begin
            found_o = 1'b1;
            pick_o  = probe;
         end
      end
   end

endmodule

// File: rtl/dga_grant_hold.sv
module dga_grant_hold #(
   parameter int PORT_CH = 32,
   parameter int CH_W    = $clog2(PORT_CH)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               win_found_i,
   input  logic [CH_W-1:0]    win_idx_i,
   input  logic               done_i,
   output logic               load_o,
   output logic [PORT_CH-1:0] gnt_o,
   output logic               valid_o,
   output logic [CH_W-1:0]    idx_o
);

   assign load_o = !valid_o && win_found_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_o <= 1'b0;
         gnt_o   <= '0;
         idx_o   <= '0;
      end else if (load_o) begin
         valid_o <= 1'b1;
         gnt_o   <= PORT_CH'(1) << win_idx_i;
         idx_o   <= win_idx_i;
      end else if (valid_o && done_i) begin
         valid_o <= 1'b0;
         gnt_o   <= '0;
         idx_o   <= '0;
      end
   end

   // R3: held grant stays put until burst-done
   a_r3_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && !done_i) |=> (valid_o && $stable(gnt_o) && $stable(idx_o)));

   // R4: burst-done releases the grant on the next cycle
   a_r4_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && done_i) |=> !valid_o);

   // R5: idle means an all-zero grant
   a_r5_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_o |-> (gnt_o == '0 && idx_o == '0));

   // R7: one-hot grant matching the index
   a_r7_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> ($countones(gnt_o) == 1 && gnt_o[idx_o]));

   // R10: burst-done while idle starts nothing by itself
   a_r10_idle_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!valid_o && !win_found_i) |=> !valid_o);

endmodule

// File: rtl/dga_arbiter.sv
module dga_arbiter
   import dga_pkg::*;
#(
   parameter int PORT_CH = 32,
   parameter int NUM_CH  = 32,
   localparam int CH_W   = $clog2(PORT_CH)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [PORT_CH-1:0] req_i,
   input  logic [PORT_CH-1:0] en_i,
   input  logic               burst_done_i,
   output logic [PORT_CH-1:0] gnt_o,
   output logic               gnt_valid_o,
   output logic [CH_W-1:0]    gnt_idx_o
);

   initial begin
      assert (PORT_CH >= 16 && (1 << CH_W) == PORT_CH)
         else $error("dga_arbiter: PORT_CH must be a power of two, at least 16");
      assert (NUM_CH >= 1 && NUM_CH <= PORT_CH)
         else $error("dga_arbiter: NUM_CH out of range");
   end

   logic [PORT_CH-1:0]    live_mask;
   logic [PORT_CH-1:0]    elig;
   logic [PORT_CH-1:0]    grp_mask  [NUM_GROUPS];
   logic                  grp_found [NUM_GROUPS];
   logic [CH_W-1:0]       grp_pick  [NUM_GROUPS];
   logic [CH_W-1:0]       grp_last  [NUM_GROUPS];
   logic                  win_found;
   logic [CH_W-1:0]       win_idx;
   logic [GRP_W-1:0]      win_grp;
   logic                  load;

   // live channels and group membership masks
   for (genvar c = 0; c < PORT_CH; c++) begin : g_mask
      assign live_mask[c] = (c < NUM_CH);
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp_bit
         assign grp_mask[g][c] = (grp_of(c) == GRP_W'(g));
      end
   end

   assign elig = req_i & en_i & live_mask;

   // one rotating picker and one pointer per group
   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
      dga_rr_pick #(.N(PORT_CH), .W(CH_W)) u_pick (
         .cand_i  (elig & grp_mask[g]),
         .last_i  (grp_last[g]),
         .found_o (grp_found[g]),
         .pick_o  (grp_pick[g])
      );

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            grp_last[g] <= CH_W'(PORT_CH - 1);
         else if (load && win_grp == GRP_W'(g))
            grp_last[g] <= win_idx;
      end
   end

   // strict priority: lowest group number with a candidate wins
   always_comb begin
      win_found = 1'b0;
      win_idx   = '0;
      win_grp   = '0;
      for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
         if (grp_found[g]) begin
            win_found = 1'b1;
            win_idx   = grp_pick[g];
            win_grp   = GRP_W'(g);
         end
      end
   end

   dga_grant_hold #(.PORT_CH(PORT_CH), .CH_W(CH_W)) u_hold (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .win_found_i (win_found),
      .win_idx_i   (win_idx),
      .done_i      (burst_done_i),
      .load_o      (load),
      .gnt_o       (gnt_o),
      .valid_o     (gnt_valid_o),
      .idx_o       (gnt_idx_o)
   );

   // channels in a group strictly better than the current winner's
   logic [PORT_CH-1:0] better_mask;
   always_comb begin
      for (int c = 0; c < PORT_CH; c++)
         better_mask[c] = (grp_of(c) < grp_of(int'(gnt_idx_o)));
   end

   // R1: a fresh winner had no eligible rival in a better group
   a_r1_strict_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!gnt_valid_o && |elig) |=> (gnt_valid_o && ((better_mask & $past(elig)) == '0)));

   // R6: a fresh winner was requesting and enabled
   a_r6_winner_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!gnt_valid_o && |elig) |=> |(gnt_o & $past(req_i & en_i)));

   // R8: no grant beyond the live channel count
   a_r8_live_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_valid_o |-> (int'(gnt_idx_o) < NUM_CH));

endmodule

// File: tb/dga_arbiter_tb.sv
module dga_arbiter_tb;

   localparam int PORT_CH = 32;
   localparam int NUM_CH  = 20;
   localparam int CH_W    = $clog2(PORT_CH);

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [PORT_CH-1:0] req = '0;
   logic [PORT_CH-1:0] en = '0;
   logic               done = 1'b0;
   logic [PORT_CH-1:0] gnt;
   logic               gvalid;
   logic [CH_W-1:0]    gidx;

   always #2.5 clk = ~clk;

   dga_arbiter #(.PORT_CH(PORT_CH), .NUM_CH(NUM_CH)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .en_i(en),
      .burst_done_i(done), .gnt_o(gnt), .gnt_valid_o(gvalid), .gnt_idx_o(gidx)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit reported = 1'b0;

   // reference model
   bit m_busy = 1'b0;
   int m_idx  = 0;
   int m_last [4] = '{31, 31, 31, 31};

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   task automatic check(string tag, bit ok, longint act, longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_edge();
      if (!m_busy) begin
         for (int g = 0; g < 4 && !m_busy; g++) begin
            for (int k = 1; k <= PORT_CH && !m_busy; k++) begin
               int i;
               i = (m_last[g] + k) % PORT_CH;
               if (i < NUM_CH && req[i] && en[i] && ((i % 16) / 4) == g) begin
                  m_busy    = 1'b1;
                  m_idx     = i;
                  m_last[g] = i;
               end
            end
         end
      end else if (done) begin
         m_busy = 1'b0;
      end
   endtask

   // one clock: model updates at the edge, outputs compared at the falling edge
   task automatic tick(string tag);
      logic [PORT_CH-1:0] exp_g;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      exp_g = m_busy ? (PORT_CH'(1) << m_idx) : '0;
      check({tag, " valid"}, gvalid == m_busy, gvalid, m_busy);
      check({tag, " grant"}, gnt == exp_g, gnt, exp_g);
      check({tag, " index"}, gidx == (m_busy ? CH_W'(m_idx) : '0), gidx, m_busy ? m_idx : 0);
   endtask

   initial begin
      #(5.0 * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      int grants12;
      logic [31:0] lfsr;

      repeat (3) @(negedge clk);
      // R5: reset state
      check("R5 reset valid", gvalid == 1'b0, gvalid, 0);
      check("R5 reset grant", gnt == '0, gnt, 0);
      rst_n = 1'b1;

      // R10: burst-done with nothing held
      done = 1'b1; tick("R10"); done = 1'b0; tick("R10");

      // R1 R2: all live channels requesting, rotation inside group 0 (0,1,2,3,16,17,...)
      en = '1; req = '1;
      for (int n = 0; n < 12; n++) begin
         tick("R1");
         done = 1'b1; tick("R2"); done = 1'b0;
      end

      // R3: request changes while a grant is held
      req = 32'h0000_0F00; tick("R3");
      for (int n = 0; n < 5; n++) begin
         req = ~req; tick("R3");
      end
      done = 1'b1; tick("R4"); done = 1'b0;
      tick("R4");

      // R6: masked channel never wins
      req = 32'h0000_0020; en = ~32'h0000_0020;
      repeat (4) tick("R6");
      en = '1; tick("R6");
      done = 1'b1; tick("R6"); done = 1'b0;

      // R8: only out-of-range channels request
      req = 32'hFFF0_0000;
      repeat (4) tick("R8");

      // R9: group 0 traffic starves channel 12
      grants12 = 0;
      req = 32'h0001_1001;
      for (int n = 0; n < 30; n++) begin
         tick("R9");
         if (gvalid && gidx == 12) grants12++;
         done = 1'b1; tick("R9"); done = 1'b0;
         if (gvalid && gidx == 12) grants12++;
      end
      check("R9 starvation", grants12 == 0, grants12, 0);
      req = '0;
      repeat (2) tick("R9");

      // R7: pseudo-random sweep against the model
      lfsr = 32'hACE1_2345;
      for (int n = 0; n < 4000; n++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         req  = lfsr & {lfsr[15:0], lfsr[31:16]};
         en   = ~(lfsr >> 5) | lfsr;
         done = lfsr[3] & lfsr[11];
         tick("R7");
      end
      done = 1'b0;
      report();
   end

endmodule